// File: doc/BRIEF.md
# Configurable Microcontroller Bus Interface

This block is the slave-side front end that lets a peripheral sit on the bus of a host microcontroller. One front end serves four host bus styles. The address and data can share pins or use separate pins, and the data path can be 8 or 16 bits wide. A two-bit setting picks the style, and that setting is taken only while reset is held. In the shared-pin styles, the address is caught from the pins while the latch strobe is high. In the separate-pin styles, the address comes straight from dedicated pins. Read data is sent to the pins that the chosen style uses for data, and every other pin stays undriven. Each tri-state pin is modelled as three signals: an input, an output and an output enable.

All host-side signals are sampled with `clk`. The active-low strobes decode into two things for the back end. The first is a combinational read request, which expects `rd_data` to be valid in the same cycle. The second is a single-cycle write beat, which carries the address, the data and the byte enables. The host bus has no way to stall, so the write beat has `wr_valid` but no ready. The back end must take a beat in any cycle where `wr_valid` is high. Back-pressure is not possible, and a dropped beat is a lost write.

Top module: `mcu_bus_front`

## Requirements
- R1: `mode_cfg` bit 1 selects separate pins and bit 0 selects the 16-bit path (00 shared 8-bit, 01 shared 16-bit, 10 separate 8-bit, 11 separate 16-bit). The value is taken on clock edges while `rst_n` is low, and changes made while out of reset have no effect.
- R2: In both shared modes, the low address byte follows `ad_lo_in` while `ale` is high. After `ale` falls, the low byte holds the value sampled at the last clock edge that saw `ale` high.
- R3: In shared 16-bit mode, the high address byte is latched from `ad_hi_in` in the same way. In shared 8-bit mode, the high byte always follows `ad_hi_in` live, and `ad_hi_oe` is never asserted.
- R4: In both separate modes, `cyc_addr` is `{ad_hi_in, ad_lo_in}` live and `ale` has no effect. Neither `ad_lo_oe` nor `ad_hi_oe` is ever asserted.
- R5: The device is selected when `(cyc_addr & SEL_MASK) == SEL_BASE`. The defaults are mask 16'hF000 and base 16'h8000.
- R6: `rd_req` and the output enables are asserted in the same cycle only while `rd_n` is low and the device is selected. Otherwise every enable is low.
- R7: During a read, data goes out on these pins: shared 8-bit drives `ad_lo_out`; shared 16-bit drives `ad_lo_out` and `ad_hi_out`; separate 8-bit drives `pa_out`; separate 16-bit drives `pa_out` and `pb_out`. The low byte is `rd_data[7:0]` and the high byte is `rd_data[15:8]`. Port B is never driven in separate 8-bit mode.
- R8: A write commits when a clock edge samples `wr_n` high after the previous edge sampled it low. `wr_valid` is then high for exactly the one cycle after that edge. The beat carries the address and data sampled at the last edge that saw `wr_n` low, and it is issued only if the device was selected at that edge.
- R9: Shared modes take write data from the address/data pins, and separate modes take it from ports A and B. In 8-bit modes, `wr_data[15:8]` is 0, `wr_be` is 2'b01, and port B and the high shared pins carry no data.
- R10: In 16-bit modes, `wr_be[1]` is `!bhe_n` and `wr_be[0]` is `!addr[0]`. Both are sampled at the same edge as the write data.
- R11: Reset clears the address latches to zero and clears `wr_valid`. In a shared mode with `ale` low, `cyc_addr` reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset; mode is captured while low |
| mode_cfg | input | 2 | Bus style: bit1 separate pins, bit0 16-bit |
| ale | input | 1 | Address latch strobe, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bhe_n | input | 1 | Upper byte enable, active low |
| ad_lo_in | input | 8 | Low shared address/data pins, input side |
| ad_lo_out | output | 8 | Low shared pins, output side |
| ad_lo_oe | output | 1 | Low shared pins drive enable |
| ad_hi_in | input | 8 | High shared address/data pins, input side |
| ad_hi_out | output | 8 | High shared pins, output side |
| ad_hi_oe | output | 1 | High shared pins drive enable |
| pa_in | input | 8 | Port A input side (low data byte) |
| pa_out | output | 8 | Port A output side |
| pa_oe | output | 1 | Port A drive enable |
| pb_in | input | 8 | Port B input side (high data byte) |
| pb_out | output | 8 | Port B output side |
| pb_oe | output | 1 | Port B drive enable |
| cyc_addr | output | 16 | Current decoded address |
| rd_req | output | 1 | Read of a selected address in progress |
| rd_data | input | 16 | Read data from back end, same cycle |
| wr_valid | output | 1 | One-cycle write beat |
| wr_addr | output | 16 | Write address |
| wr_data | output | 16 | Write data |
| wr_be | output | 2 | Write byte enables, bit1 upper byte |

## Verification
A stale or wrong mode register shows up at once as the wrong set of output enables on the first read, for example shared pins driven in a separate mode. A latch that fails to hold corrupts `cyc_addr` on the very cycle that the shared pins turn to carry data. A bad write edge detector shows up one cycle after the strobe is released, as a missing, doubled or misdirected `wr_valid` beat. The byte-enable and zero-fill errors appear in that same beat.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
  typedef enum logic [1:0] {
    MODE_MUX8  = 2'b00,
    MODE_MUX16 = 2'b01,
    MODE_SEP8  = 2'b10,
    MODE_SEP16 = 2'b11
  } bus_mode_e;

  function automatic logic mode_sep(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_wide(input logic [1:0] m);
    return m[0];
  endfunction

  // lane 0 is used in every mode, lane 1 only on a 16-bit path
  function automatic logic lane_used(input logic [1:0] m, input int lane);
    return (lane == 0) || m[0];
  endfunction
endpackage

// File: rtl/mbf_addr_capture.sv
module mbf_addr_capture
  import mbf_pkg::*;
#(
  parameter int BW = 8,
  localparam int AW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          ale,
  input  logic [BW-1:0] lo_in,
  input  logic [BW-1:0] hi_in,
  output logic [AW-1:0] addr
);
  for (genvar i = 0; i < 2; i++) begin : g_lane
    logic [BW-1:0] pin;
    logic [BW-1:0] held;
    logic          latch_en;

    assign pin      = (i == 0) ? lo_in : hi_in;
    // a lane latches only where its pins double as data pins
    assign latch_en = !mode_sep(mode) && lane_used(mode, i);

    always_ff @(posedge clk) begin
      if (!rst_n)             held <= '0;
      else if (ale && latch_en) held <= pin;
    end

    assign addr[i*BW +: BW] = (latch_en && !ale) ? held : pin;
  end
endmodule

// File: rtl/mbf_read_steer.sv
module mbf_read_steer
  import mbf_pkg::*;
#(
  parameter int BW = 8,
  localparam int DW = 2 * BW
) (
  input  logic [1:0]    mode,
  input  logic          rd_active,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] shared_out,
  output logic [1:0]    shared_oe,
  output logic [DW-1:0] port_out,
  output logic [1:0]    port_oe
);
  for (genvar i = 0; i < 2; i++) begin : g_lane
    logic drive;
    assign drive                  = rd_active && lane_used(mode, i);
    assign shared_out[i*BW +: BW] = rd_data[i*BW +: BW];
    assign port_out[i*BW +: BW]   = rd_data[i*BW +: BW];
    assign shared_oe[i]           = drive && !mode_sep(mode);
    assign port_oe[i]             = drive && mode_sep(mode);
  end
endmodule

// File: rtl/mbf_write_commit.sv
module mbf_write_commit
  import mbf_pkg::*;
#(
  parameter int BW = 8,
  localparam int DW = 2 * BW,
  localparam int AW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          wr_n,
  input  logic          bhe_n,
  input  logic [AW-1:0] addr,
  input  logic          sel,
  input  logic [DW-1:0] shared_in,
  input  logic [DW-1:0] port_in,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [1:0]    wr_be
);
  logic          strobe_seen;
  logic          cap_sel;
  logic          cap_hi_en;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_data;
  logic [DW-1:0] src_data;
  logic          release_edge;

  assign src_data = mode_sep(mode) ? port_in : shared_in;
  assign release_edge = strobe_seen && wr_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_seen <= 1'b0;
      cap_sel     <= 1'b0;
      cap_hi_en   <= 1'b0;
      cap_addr    <= '0;
      cap_data    <= '0;
      wr_valid    <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      wr_be       <= '0;
    end else begin
      strobe_seen <= !wr_n;
      if (!wr_n) begin
        cap_sel   <= sel;
        cap_hi_en <= !bhe_n;
        cap_addr  <= addr;
        cap_data  <= mode_wide(mode) ? src_data : {{BW{1'b0}}, src_data[BW-1:0]};
      end
      wr_valid <= release_edge && cap_sel;
      if (release_edge) begin
        wr_addr <= cap_addr;
        wr_data <= cap_data;
        wr_be   <= mode_wide(mode) ? {cap_hi_en, !cap_addr[0]} : 2'b01;
      end
    end
  end
endmodule

// File: rtl/mcu_bus_front.sv
module mcu_bus_front
  import mbf_pkg::*;
#(
  parameter int          BW       = 8,
  parameter logic [15:0] SEL_MASK = 16'hF000,
  parameter logic [15:0] SEL_BASE = 16'h8000,
  localparam int AW = 2 * BW,
  localparam int DW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_cfg,
  input  logic          ale,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          bhe_n,
  input  logic [BW-1:0] ad_lo_in,
  output logic [BW-1:0] ad_lo_out,
  output logic          ad_lo_oe,
  input  logic [BW-1:0] ad_hi_in,
  output logic [BW-1:0] ad_hi_out,
  output logic          ad_hi_oe,
  input  logic [BW-1:0] pa_in,
  output logic [BW-1:0] pa_out,
  output logic          pa_oe,
  input  logic [BW-1:0] pb_in,
  output logic [BW-1:0] pb_out,
  output logic          pb_oe,
  output logic [AW-1:0] cyc_addr,
  output logic          rd_req,
  input  logic [DW-1:0] rd_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [1:0]    wr_be
);
  bus_mode_e     mode_q;
  logic          sel;
  logic [DW-1:0] shared_out;
  logic [DW-1:0] port_out;
  logic [1:0]    shared_oe;
  logic [1:0]    port_oe;

  // bus style is frozen outside reset
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= bus_mode_e'(mode_cfg);
  end

  mbf_addr_capture #(.BW(BW)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode_q),
    .ale   (ale),
    .lo_in (ad_lo_in),
    .hi_in (ad_hi_in),
    .addr  (cyc_addr)
  );

  assign sel    = (cyc_addr & SEL_MASK[AW-1:0]) == SEL_BASE[AW-1:0];
  assign rd_req = !rd_n && sel;

  mbf_read_steer #(.BW(BW)) u_rd (
    .mode       (mode_q),
    .rd_active  (rd_req),
    .rd_data    (rd_data),
    .shared_out (shared_out),
    .shared_oe  (shared_oe),
    .port_out   (port_out),
    .port_oe    (port_oe)
  );

  assign ad_lo_out = shared_out[BW-1:0];
  assign ad_hi_out = shared_out[DW-1:BW];
  assign ad_lo_oe  = shared_oe[0];
  assign ad_hi_oe  = shared_oe[1];
  assign pa_out    = port_out[BW-1:0];
  assign pb_out    = port_out[DW-1:BW];
  assign pa_oe     = port_oe[0];
  assign pb_oe     = port_oe[1];

  mbf_write_commit #(.BW(BW)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_q),
    .wr_n      (wr_n),
    .bhe_n     (bhe_n),
    .addr      (cyc_addr),
    .sel       (sel),
    .shared_in ({ad_hi_in, ad_lo_in}),
    .port_in   ({pb_in, pa_in}),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_be     (wr_be)
  );
endmodule

// File: rtl/mbf_front_chk.sv
module mbf_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_q,
  input logic       rd_n,
  input logic       wr_n,
  input logic       ad_lo_oe,
  input logic       ad_hi_oe,
  input logic       pa_oe,
  input logic       pb_oe,
  input logic       wr_valid,
  input logic [1:0] wr_be
);
  p_mode_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));

  p_hi_no_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00) |-> !ad_hi_oe);

  p_shared_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[1] |-> !(ad_lo_oe || ad_hi_oe));

  p_idle_tristate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |-> !(ad_lo_oe || ad_hi_oe || pa_oe || pb_oe));

  p_port_b_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b10) |-> !pb_oe);

  p_ports_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[1] |-> !(pa_oe || pb_oe));

  p_single_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  p_after_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ($past(wr_n) && !$past(wr_n, 2)));

  p_narrow_be_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !mode_q[0]) |-> (wr_be == 2'b01));
endmodule

bind mcu_bus_front mbf_front_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_q   (mode_q),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .ad_lo_oe (ad_lo_oe),
  .ad_hi_oe (ad_hi_oe),
  .pa_oe    (pa_oe),
  .pb_oe    (pb_oe),
  .wr_valid (wr_valid),
  .wr_be    (wr_be)
);

// File: tb/test_mcu_bus_front.sv
module test_mcu_bus_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_cfg = 2'b00;
  logic        ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1, bhe_n = 1'b1;
  logic [7:0]  ad_lo_in = '0, ad_hi_in = '0, pa_in = '0, pb_in = '0;
  logic [7:0]  ad_lo_out, ad_hi_out, pa_out, pb_out;
  logic        ad_lo_oe, ad_hi_oe, pa_oe, pb_oe;
  logic [15:0] cyc_addr, wr_addr, wr_data;
  logic [15:0] rd_data = '0;
  logic        rd_req, wr_valid;
  logic [1:0]  wr_be;
  int          errs = 0;
  int          checks = 0;
  logic [1:0]  cur_mode = 2'b00;

  always #2 clk = ~clk;

  mcu_bus_front i_mcu_bus_front (
    .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .bhe_n(bhe_n),
    .ad_lo_in(ad_lo_in), .ad_lo_out(ad_lo_out), .ad_lo_oe(ad_lo_oe),
    .ad_hi_in(ad_hi_in), .ad_hi_out(ad_hi_out), .ad_hi_oe(ad_hi_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .cyc_addr(cyc_addr), .rd_req(rd_req), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be)
  );

  // {is_write, mode, bhe_n, addr, data}
  localparam logic [35:0] VEC [12] = '{
    {1'b0, 2'b00, 1'b1, 16'h8012, 16'h00A5},
    {1'b0, 2'b00, 1'b1, 16'h1234, 16'h5555},
    {1'b1, 2'b00, 1'b1, 16'h8044, 16'h3377},
    {1'b0, 2'b01, 1'b1, 16'h8123, 16'hBEEF},
    {1'b1, 2'b01, 1'b0, 16'h8046, 16'hABCD},
    {1'b1, 2'b01, 1'b1, 16'h8046, 16'h1357},
    {1'b1, 2'b01, 1'b0, 16'h8047, 16'h2468},
    {1'b0, 2'b10, 1'b1, 16'h8F00, 16'h1234},
    {1'b1, 2'b10, 1'b0, 16'h8100, 16'h9A9B},
    {1'b0, 2'b11, 1'b1, 16'h8ABC, 16'hC3D2},
    {1'b1, 2'b11, 1'b0, 16'h8200, 16'hF00D},
    {1'b1, 2'b11, 1'b1, 16'h4000, 16'h1111}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic is_sel(input logic [15:0] a);
    return (a & 16'hF000) == 16'h8000;
  endfunction

  task automatic idle_pins();
    ale = 0; rd_n = 1; wr_n = 1; bhe_n = 1;
  endtask

  task automatic reset_to(input logic [1:0] m);
    @(negedge clk);
    rst_n = 0; mode_cfg = m; idle_pins();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    cur_mode = m;
  endtask

  // address phase: latch strobe in shared modes, dedicated pins otherwise
  task automatic put_addr(input logic [15:0] a);
    @(negedge clk);
    ad_lo_in = a[7:0]; ad_hi_in = a[15:8];
    ale = !cur_mode[1];
    @(posedge clk);
    @(negedge clk);
    ale = 0;
  endtask

  task automatic run_read(input logic [15:0] a, input logic [15:0] d);
    logic s, sep, wide;
    put_addr(a);
    sep = cur_mode[1]; wide = cur_mode[0]; s = is_sel(a);
    if (!sep) begin
      ad_lo_in = 8'h5A;
      if (wide) ad_hi_in = 8'hC6;
    end
    rd_data = d; rd_n = 0;
    #1;
    chk("R2/R3/R4 addr", cyc_addr, a);
    chk("R5/R6 rd_req", rd_req, s);
    chk("R6/R7 oe set", {ad_lo_oe, ad_hi_oe, pa_oe, pb_oe},
        {s && !sep, s && !sep && wide, s && sep, s && sep && wide});
    if (s && !sep) chk("R7 shared lo", ad_lo_out, d[7:0]);
    if (s && !sep && wide) chk("R7 shared hi", ad_hi_out, d[15:8]);
    if (s && sep) chk("R7 port a", pa_out, d[7:0]);
    if (s && sep && wide) chk("R7 port b", pb_out, d[15:8]);
    @(negedge clk);
    rd_n = 1;
  endtask

  task automatic run_write(input logic [15:0] a, input logic [15:0] d, input logic bn);
    logic s, sep, wide;
    sep = cur_mode[1]; wide = cur_mode[0]; s = is_sel(a);
    if (sep) begin pa_in = d[7:0]; pb_in = d[15:8]; end
    put_addr(a);
    if (!sep) begin
      ad_lo_in = d[7:0];
      ad_hi_in = wide ? d[15:8] : a[15:8];
    end
    wr_n = 0; bhe_n = bn;
    @(posedge clk);
    @(negedge clk);
    wr_n = 1; bhe_n = 1;
    ad_lo_in = 8'hEE; pa_in = 8'hEE; pb_in = 8'hEE;
    @(posedge clk); #1;
    chk("R8 valid", wr_valid, s);
    if (s) begin
      chk("R8 addr", wr_addr, a);
      chk("R9 data", wr_data, wide ? d : {8'h00, d[7:0]});
      chk("R10 be", wr_be, wide ? {!bn, !a[0]} : 2'b01);
    end
    @(posedge clk); #1;
    chk("R8 single beat", wr_valid, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    reset_to(2'b00);
    foreach (VEC[i]) begin
      if (VEC[i][34:33] != cur_mode) reset_to(VEC[i][34:33]);
      if (VEC[i][35]) run_write(VEC[i][31:16], VEC[i][15:0], VEC[i][32]);
      else            run_read(VEC[i][31:16], VEC[i][15:0]);
    end

    // R11: latches cleared and no beat after reset
    put_addr(16'h8777);
    reset_to(2'b01);
    #1;
    chk("R11 addr cleared", cyc_addr, 16'h0000);
    chk("R11 no valid", wr_valid, 1'b0);
    chk("R11 no oe", {ad_lo_oe, ad_hi_oe, pa_oe, pb_oe}, 4'b0000);

    // R2/R3: latch holds in shared 16-bit once pins change
    put_addr(16'h8034);
    ad_lo_in = 8'hFF; ad_hi_in = 8'h11;
    @(posedge clk); #1;
    chk("R2 low held", cyc_addr[7:0], 8'h34);
    chk("R3 high held", cyc_addr[15:8], 8'h80);

    // R1: mode change outside reset ignored
    @(negedge clk);
    mode_cfg = 2'b10;
    run_read(16'h8005, 16'h7E81);

    // R6: strobe idle keeps all pins undriven
    @(negedge clk); #1;
    chk("R6 idle oe", {ad_lo_oe, ad_hi_oe, pa_oe, pb_oe, rd_req}, 5'b0);

    // R3: shared 8-bit high byte follows pins live
    reset_to(2'b00);
    put_addr(16'h0012);
    ad_hi_in = 8'h9A;
    #1;
    chk("R3 hi live", cyc_addr, 16'h9A12);

    // R4: separate mode ignores the latch strobe
    reset_to(2'b11);
    @(negedge clk);
    ale = 1; ad_lo_in = 8'h01; ad_hi_in = 8'h80;
    @(posedge clk);
    @(negedge clk);
    ale = 0; ad_lo_in = 8'h02; rd_n = 0; rd_data = 16'h4321;
    #1;
    chk("R4 live addr", cyc_addr, 16'h8002);
    chk("R4 shared quiet", {ad_lo_oe, ad_hi_oe}, 2'b00);
    chk("R7 port b", pb_out, 8'h43);
    @(negedge clk);
    rd_n = 1;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule